// File: doc/BRIEF.md
# Eight-Channel Low-Side Fault Supervisor

This block watches eight low-side output channels. For each one it takes the channel's on/off command, a comparator bit that says whether the output voltage sits above the diagnostic threshold, and an overcurrent flag. The two lowest channels also take an over-temperature flag. It filters these conditions, turns off a channel that has a hard fault, asks for current regulation on the two lamp-type channels, keeps a per-channel overload latch, and builds an eight-bit status word for the serial interface to shift out.

Channels 1 and 2 (bits 0 and 1) are meant for loads with inrush current. On sustained overcurrent they request current regulation and stay on. They are switched off only after a sustained over-temperature. Channels 3 to 8 switch off once overcurrent has lasted a short delay. Every duration is a parameter counted in system clock cycles, and a counter restarts whenever its condition drops out. A falling edge on the serial chip select copies the fault latches into the status word and clears the latches. A channel that was switched off stays off until its latch has been cleared and the next chip-select rising edge delivers a new command.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is held and on the first cycle after it, no overload latch is set, `stat_word` is 0, `creg_req` is 0 and `drv_en` equals `cmd_on`.
- R2: Bit i of `cmd_on` drives bit i of `drv_en`, with bit 0 being channel 1, on any channel that is not locked out.
- R3: On channels 3 to 8, overcurrent on a driven channel for SCB_CYC consecutive clock edges sets that channel's overload latch and clears its `drv_en` bit after the SCB_CYC-th edge. A shorter burst leaves both unchanged.
- R4: On channels 1 and 2, overcurrent on a driven channel for FILT_CYC consecutive edges raises `creg_req` after the FILT_CYC-th edge. The drive stays on and no latch is set. `creg_req` falls in the same cycle that the overcurrent flag falls.
- R5: On channels 1 and 2, over-temperature on a driven channel for FILT_CYC consecutive edges sets the overload latch and turns the channel off after the FILT_CYC-th edge.
- R6: A channel that was switched off stays off while chip select is low. Its drive returns, if still commanded, one edge after the first chip-select rising edge at which its overload latch is already clear.
- R7: The overload latches read 0 one edge after chip select falls, unless a new trip occurs on that same edge.
- R8: In serial-control mode, an off channel reports 1 when the voltage stays above the threshold and 0 after it has been below it. An on channel reports 0 when the voltage stays below the threshold and 1 after it has been above it or after the channel has tripped.
- R9: For channels 1 and 2 with their `pin_sel` bit set (direct-pin control), the bit is 1 while no fault was seen and 0 otherwise. For an on channel this is the inverse of R8.
- R10: `stat_word` is loaded only on a chip-select falling edge, from the fault latches as they were before that edge clears them. A fault that has already gone therefore still appears in the first read and is absent from the second.
- R11: On channels 1 and 2, a diagnostic condition must last FILT_CYC consecutive edges before it is recorded, so a shorter one is not recorded. On channels 3 to 8 a single edge is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Serial chip select, active low; its edges clear latches and release lockouts |
| pin_sel | input | N_REG | Per low channel: 1 = controlled by direct pin, 0 = by serial command |
| cmd_on | input | N_CH | Effective on command per channel |
| v_above | input | N_CH | Comparator: output voltage above the diagnostic threshold |
| oc_flag | input | N_CH | Overcurrent detected |
| hot_flag | input | N_REG | Over-temperature on channels 1 and 2 |
| drv_en | output | N_CH | Gate enable per channel |
| creg_req | output | N_REG | Current-regulation request for channels 1 and 2 |
| ovl_latch | output | N_CH | Overload latches |
| stat_word | output | N_CH | Status word for serial read-out |

## Verification
A shutdown for channels 3 to 8 is due on the SCB_CYC-th edge after overcurrent appears. Regulation, thermal shutdown and diagnostic capture on channels 1 and 2 are due on the FILT_CYC-th edge. The bench checks each of these both one edge early, where nothing may have changed yet, and on the due edge. `stat_word` and the latch clear are due one edge after chip select falls, and the lockout release one edge after it rises. The regulation request is combinational on the flag, so its drop is checked a moment after the flag falls. Inputs change just after a falling clock edge, and results are sampled at a later falling edge, so every count of edges is exact.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int N_CH     = 8,
  parameter int N_REG    = 2,
  parameter int FILT_CYC = 750,
  parameter int SCB_CYC  = 150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic [N_REG-1:0] pin_sel,
  input  logic [N_CH-1:0]  cmd_on,
  input  logic [N_CH-1:0]  v_above,
  input  logic [N_CH-1:0]  oc_flag,
  input  logic [N_REG-1:0] hot_flag,
  output logic [N_CH-1:0]  drv_en,
  output logic [N_REG-1:0] creg_req,
  output logic [N_CH-1:0]  ovl_latch,
  output logic [N_CH-1:0]  stat_word
);

  localparam int FW = $clog2(FILT_CYC + 1);

  logic            cs_q;
  logic            cs_fall, cs_rise;
  logic [N_CH-1:0] lock_q, ovl_q, flt_q, snap_q;
  logic [N_CH-1:0] trip, dgq, stat_now;

  assign cs_fall   = cs_q & ~cs_n;
  assign cs_rise   = ~cs_q & cs_n;
  assign drv_en    = cmd_on & ~lock_q;
  assign ovl_latch = ovl_q;
  assign stat_word = snap_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam int OLIM = (g < N_REG) ? FILT_CYC : SCB_CYC;
    localparam int OW   = $clog2(OLIM + 1);

    logic [OW-1:0] oc_cnt;
    logic          oc_cond, d_cond;

    assign oc_cond = drv_en[g] & oc_flag[g];
    assign d_cond  = cmd_on[g] ? v_above[g] : ~v_above[g];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     oc_cnt <= '0;
      else if (!oc_cond)              oc_cnt <= '0;
      else if (oc_cnt != OW'(OLIM))   oc_cnt <= oc_cnt + 1'b1;

    if (g < N_REG) begin : g_reg
      logic [FW-1:0] th_cnt, dg_cnt;
      logic          th_cond;

      assign th_cond = drv_en[g] & hot_flag[g];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                       th_cnt <= '0;
        else if (!th_cond)                th_cnt <= '0;
        else if (th_cnt != FW'(FILT_CYC)) th_cnt <= th_cnt + 1'b1;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                       dg_cnt <= '0;
        else if (!d_cond)                 dg_cnt <= '0;
        else if (dg_cnt != FW'(FILT_CYC)) dg_cnt <= dg_cnt + 1'b1;

      assign creg_req[g] = oc_cond & (oc_cnt == OW'(OLIM));
      assign trip[g]     = th_cond & (th_cnt >= FW'(FILT_CYC - 1));
      assign dgq[g]      = d_cond & (dg_cnt >= FW'(FILT_CYC - 1));
      assign stat_now[g] = (pin_sel[g] | ~cmd_on[g]) ? ~flt_q[g] : flt_q[g];

      // R4: regulation is only requested after overcurrent has been present
      assert_creg_needs_oc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(creg_req[g]) |-> $past(oc_flag[g]));
    end else begin : g_sw
      assign trip[g]     = oc_cond & (oc_cnt >= OW'(OLIM - 1));
      assign dgq[g]      = d_cond;
      assign stat_now[g] = cmd_on[g] ? flt_q[g] : ~flt_q[g];
    end

    // R7: a set overload latch survives until a chip-select fall
    assert_ovl_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_q[g] && !cs_fall) |=> ovl_q[g]);

    // R6: lockout ends only at a chip-select rise with the latch already clear
    assert_lock_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_q[g]) |-> ($past(cs_rise) && !$past(ovl_q[g])));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q   <= 1'b1;
      ovl_q  <= '0;
      lock_q <= '0;
      flt_q  <= '0;
      snap_q <= '0;
    end else begin
      cs_q   <= cs_n;
      ovl_q  <= cs_fall ? trip : (ovl_q | trip);
      lock_q <= trip | (lock_q & ~({N_CH{cs_rise}} & ~ovl_q));
      flt_q  <= cs_fall ? '0 : (flt_q | dgq | ovl_q);
      if (cs_fall) snap_q <= stat_now;
    end

  // R10: the status word changes only on a chip-select fall
  assert_stat_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(snap_q));

endmodule

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
  localparam int NC = 8, NR = 2, FILT = 6, SCB = 3;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
  logic [NR-1:0] pin_sel = '0, hot_flag = '0;
  logic [NC-1:0] cmd_on = '0, v_above = '0, oc_flag = '0;
  logic [NC-1:0] drv_en, ovl_latch, stat_word;
  logic [NR-1:0] creg_req;
  int ntot = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_supervisor #(.N_CH(NC), .N_REG(NR), .FILT_CYC(FILT), .SCB_CYC(SCB)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pin_sel(pin_sel), .cmd_on(cmd_on),
    .v_above(v_above), .oc_flag(oc_flag), .hot_flag(hot_flag), .drv_en(drv_en),
    .creg_req(creg_req), .ovl_latch(ovl_latch), .stat_word(stat_word));

  // {pin_sel, cmd_on, v_above, expected status}
  localparam logic [25:0] VEC [7] = '{
    {2'b00, 8'h00, 8'hFF, 8'hFF},
    {2'b00, 8'hFF, 8'h00, 8'h00},
    {2'b00, 8'hF0, 8'h3C, 8'h3C},
    {2'b11, 8'h03, 8'h00, 8'h03},
    {2'b11, 8'h03, 8'h03, 8'h00},
    {2'b01, 8'hA5, 8'h5A, 8'h5B},
    {2'b10, 8'h00, 8'hFE, 8'hFE}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();  cs_n = 1'b0; tick(1); endtask
  task automatic cs_high(); cs_n = 1'b1; tick(1); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      ntot++; nbad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    cmd_on = 8'hAA;
    tick(3);
    chk("R1 drv in reset", drv_en, 8'hAA);
    rst_n = 1'b1;
    tick(1);
    chk("R1 ovl", ovl_latch, 0);
    chk("R1 stat", stat_word, 0);
    chk("R1 creg", creg_req, 0);
    chk("R1 drv", drv_en, 8'hAA);

    // status polarity table (R8, R9) and drive following (R2)
    for (int i = 0; i < 7; i++) begin
      {pin_sel, cmd_on, v_above} = VEC[i][25:8];
      tick(10);
      chk("R2 drv", drv_en, cmd_on);
      cs_low(); cs_high(); tick(10);
      cs_low();
      chk((i >= 3) ? "R9 status" : "R8 status", stat_word, VEC[i][7:0]);
      chk("R1 no ovl", ovl_latch, 0);
      cs_high();
    end

    // R3: short burst, then full overcurrent on channel 3
    pin_sel = 0; cmd_on = 8'hFF; v_above = 0;
    cs_low(); cs_high(); tick(2);
    oc_flag[2] = 1; tick(SCB - 1); oc_flag[2] = 0; tick(1);
    chk("R3 burst no latch", ovl_latch, 0);
    chk("R3 burst drv", drv_en, 8'hFF);
    oc_flag[2] = 1; tick(SCB - 1);
    chk("R3 drv before delay", drv_en, 8'hFF);
    tick(1);
    chk("R3 drv off", drv_en, 8'hFB);
    chk("R3 latch", ovl_latch, 8'h04);
    oc_flag[2] = 0; tick(4);
    chk("R6 stays off", drv_en, 8'hFB);
    cs_low();
    chk("R7 latch cleared", ovl_latch, 0);
    chk("R8 tripped on-channel reports 1", stat_word[2], 1);
    tick(3);
    chk("R6 off while cs low", drv_en, 8'hFB);
    cs_high();
    chk("R6 drive resumes", drv_en, 8'hFF);

    // R4: regulation on channel 1
    oc_flag[0] = 1; tick(FILT - 1);
    chk("R4 creg early", creg_req, 0);
    tick(1);
    chk("R4 creg", creg_req, 2'b01);
    tick(20);
    chk("R4 drv kept", drv_en, 8'hFF);
    chk("R4 no latch", ovl_latch, 0);
    oc_flag[0] = 0; #1;
    chk("R4 creg drop", creg_req, 0);
    tick(1);

    // R5: thermal on channel 2
    hot_flag[1] = 1; tick(FILT - 1);
    chk("R5 drv before filter", drv_en, 8'hFF);
    tick(1);
    chk("R5 drv off", drv_en, 8'hFD);
    chk("R5 latch", ovl_latch, 8'h02);
    hot_flag[1] = 0; tick(2);
    cs_low(); cs_high();
    chk("R6 drive resumes ch2", drv_en, 8'hFF);

    // R11 and R10: diagnostic filtering and stale first read
    tick(10); cs_low(); cs_high(); tick(10); cs_low(); cs_high();
    v_above[0] = 1; tick(FILT - 1); v_above[0] = 0; tick(2);
    cs_low();
    chk("R11 short glitch ignored", stat_word, 0);
    cs_high(); tick(3);
    v_above[0] = 1; tick(FILT + 1); v_above[0] = 0; tick(3);
    cs_low();
    chk("R11 long fault recorded", stat_word, 8'h01);
    cs_high(); tick(3);
    cs_low();
    chk("R10 second read clean", stat_word, 0);
    cs_high();
    v_above[3] = 1; tick(1); v_above[3] = 0; tick(2);
    cs_low();
    chk("R11 immediate on ch4", stat_word, 8'h08);
    cs_high(); tick(2);
    cs_low();
    chk("R10 ch4 second read", stat_word, 0);
    cs_high();

    done = 1;
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule